// File: doc/BRIEF.md
# Physical register free list

This block keeps the set of unmapped physical registers for a register-renaming stage. Integer and floating-point registers share one index space: indices below the physical integer count are integer registers, and the indices from there up to the total are floating-point registers. Each class has its own first-in-first-out pool. An allocation takes the oldest free index of the requested class, so indices come back into use in the order they were released.

Rename logic asks for an index on an allocate port. The head of each pool is always visible, and the pop takes effect at the next clock edge. Retiring instructions hand indices back in one of two ways. A generic release port picks the pool from the index value. Two class-specific ports push straight into their own pool. A shadow bit per register records whether the register is free. It catches freeing a register twice and handing out a register that is not free. Separate flags report an allocation from an empty pool and a release into a full pool.

Top module: `phys_reg_freelist`

## Requirements
- R1: After reset, the integer pool holds indices N_LOG_INT up to N_PHYS_INT-1 in ascending order, head first. The floating-point pool holds N_PHYS_INT+N_LOG_FP up to TOTAL-1 in ascending order. Every lower index of each class counts as mapped, which means not free.
- R2: While a pool is not empty, its alloc index output shows its oldest entry. When the alloc request is high at a clock edge, that entry is removed, so indices are handed out in the order they were released.
- R3: The generic release port sends an index below N_PHYS_INT to the integer pool. It sends an index from N_PHYS_INT to TOTAL-1 to the floating-point pool. It drops an index of TOTAL or more, leaving both pools unchanged.
- R4: Each class-specific release port appends its index to its own pool with no range check. If the generic port and a class port target the same pool in one cycle, the generic index is appended first.
- R5: Each pool reports its number of free entries and a not-empty flag. The flag is high exactly when that number is non-zero.
- R6: An alloc request to an empty pool leaves the pool unchanged and raises err_empty_alloc for the one cycle after that edge.
- R7: A release of an index below TOTAL whose free bit is already set raises err_double_free for the following cycle. The index is still appended if the pool has room. Releases are checked after the same cycle's allocations, in the order generic, integer, floating-point.
- R8: An allocation that returns an index below TOTAL whose free bit is clear raises err_bad_alloc for the following cycle. An allocation clears the bit, and any release sets it.
- R9: An allocation and a release to the same pool in one cycle are both carried out. The count is unchanged, and the released index goes in at the tail.
- R10: Each pool's depth equals its class's physical count. A release that finds no room, after that cycle's pop is taken into account, is dropped and raises err_overflow for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| int_alloc_req | input | 1 | Take the integer pool head at this edge |
| int_alloc_idx | output | IW | Oldest free integer index |
| fp_alloc_req | input | 1 | Take the floating-point pool head at this edge |
| fp_alloc_idx | output | IW | Oldest free floating-point index |
| rel_valid | input | 1 | Generic release strobe |
| rel_idx | input | IW | Generic release index, routed by range |
| int_rel_valid | input | 1 | Integer-class release strobe |
| int_rel_idx | input | IW | Index pushed into the integer pool |
| fp_rel_valid | input | 1 | Floating-point-class release strobe |
| fp_rel_idx | input | IW | Index pushed into the floating-point pool |
| int_nonempty | output | 1 | Integer pool holds at least one entry |
| int_free_cnt | output | ICW | Integer pool occupancy |
| fp_nonempty | output | 1 | Floating-point pool holds at least one entry |
| fp_free_cnt | output | FCW | Floating-point pool occupancy |
| err_empty_alloc | output | 1 | Allocation attempted on an empty pool |
| err_double_free | output | 1 | Release of a register already free |
| err_bad_alloc | output | 1 | Allocation of a register not marked free |
| err_overflow | output | 1 | Release dropped because a pool was full |

## Verification
The alloc index outputs are combinational from the pool heads, so they are compared in the same cycle as the request, before the edge that pops. Counts, not-empty flags, the new heads and all four error flags are registered. They are due one edge after the stimulus, and the bench samples them at the falling edge that follows that rising edge, when the inputs have been withdrawn. A queue-based model in the bench applies each cycle's operations in the stated order (pops, then generic, integer and floating-point releases), and the expected values come from that model.

// File: rtl/frl_pkg.sv
package frl_pkg;

    typedef enum logic [1:0] {
        RCLS_INT  = 2'd0,
        RCLS_FP   = 2'd1,
        RCLS_DROP = 2'd2
    } rcls_e;

    // Classify an index into the shared physical index space.
    function automatic rcls_e route_idx(input int idx, input int n_int, input int n_tot);
        if (idx < n_int) begin
            return RCLS_INT;
        end
        if (idx < n_tot) begin
            return RCLS_FP;
        end
        return RCLS_DROP;
    endfunction

endpackage

// File: rtl/frl_pool.sv
module frl_pool #(
    parameter int DEPTH = 8,
    parameter int BASE  = 0,
    parameter int SKIP  = 4,
    parameter int IW    = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic          push0_v,
    input  logic [IW-1:0] push0_idx,
    input  logic          push1_v,
    input  logic [IW-1:0] push1_idx,
    output logic [IW-1:0] head_idx,
    output logic          nonempty,
    output logic [CW-1:0] count,
    output logic          err_empty,
    output logic          err_ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int INIT_N = DEPTH - SKIP;
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [PW-1:0] TAIL0 = PW'(INIT_N % DEPTH);

    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] hd;
    logic [PW-1:0] tl;
    logic [PW-1:0] tl1;
    logic [CW-1:0] cnt;
    logic          pop_ok;
    logic          acc0;
    logic          acc1;
    int            room;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok = pop_req && (cnt != '0);
        room   = DEPTH - int'(cnt) + (pop_ok ? 1 : 0);
        acc0   = push0_v && (room >= 1);
        acc1   = push1_v && (room >= (acc0 ? 2 : 1));
        tl1    = acc0 ? bump(tl) : tl;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            localparam logic [IW-1:0] RVAL = (g < INIT_N) ? IW'(BASE + SKIP + g) : '0;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= RVAL;
                end else if (acc0 && (tl == PW'(g))) begin
                    mem[g] <= push0_idx;
                end else if (acc1 && (tl1 == PW'(g))) begin
                    mem[g] <= push1_idx;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd        <= '0;
            tl        <= TAIL0;
            cnt       <= CW'(INIT_N);
            err_empty <= 1'b0;
            err_ovf   <= 1'b0;
        end else begin
            hd        <= pop_ok ? bump(hd) : hd;
            tl        <= acc1 ? bump(tl1) : tl1;
            cnt       <= cnt + CW'(acc0) + CW'(acc1) - CW'(pop_ok);
            err_empty <= pop_req && (cnt == '0);
            err_ovf   <= (push0_v && !acc0) || (push1_v && !acc1);
        end
    end

    assign head_idx = mem[hd];
    assign nonempty = (cnt != '0);
    assign count    = cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= DEPTH); // R10
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt == '0 && !push0_v && !push1_v) |=> (cnt == '0 && err_empty)); // R6
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt != '0 && !push0_v && !push1_v) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt != '0 && push0_v && !push1_v) |=> $stable(cnt)); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) == DEPTH && !pop_req && push0_v) |=> (err_ovf && $stable(cnt))); // R10

endmodule

// File: rtl/frl_shadow.sv
module frl_shadow #(
    parameter int TOTAL  = 14,
    parameter int IW     = 4,
    parameter int INT_LO = 4,
    parameter int INT_HI = 8,
    parameter int FP_LO  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ai_v,
    input  logic [IW-1:0] ai_idx,
    input  logic          af_v,
    input  logic [IW-1:0] af_idx,
    input  logic          rg_v,
    input  logic [IW-1:0] rg_idx,
    input  logic          ri_v,
    input  logic [IW-1:0] ri_idx,
    input  logic          rf_v,
    input  logic [IW-1:0] rf_idx,
    output logic          err_dbl,
    output logic          err_bad
);
    localparam int NOPS = 5;

    function automatic logic [TOTAL-1:0] init_bits();
        logic [TOTAL-1:0] r;
        for (int k = 0; k < TOTAL; k++) begin
            r[k] = ((k >= INT_LO) && (k < INT_HI)) || ((k >= FP_LO) && (k < TOTAL));
        end
        return r;
    endfunction

    function automatic logic is_set(input logic [TOTAL-1:0] v, input logic [IW-1:0] i);
        logic r;
        r = 1'b0;
        for (int k = 0; k < TOTAL; k++) begin
            if (int'(i) == k) begin
                r = v[k];
            end
        end
        return r;
    endfunction

    localparam logic [TOTAL-1:0] INIT = init_bits();

    logic [TOTAL-1:0] bits;
    logic [TOTAL-1:0] nxt;
    logic             dbl;
    logic             bad;
    logic [NOPS-1:0]  ov;
    logic [NOPS-1:0]  os;
    logic [IW-1:0]    oi [NOPS];

    // Operation order: allocations, then generic, integer, float releases.
    assign ov    = {rf_v, ri_v, rg_v, af_v, ai_v};
    assign os    = 5'b11100;
    assign oi[0] = ai_idx;
    assign oi[1] = af_idx;
    assign oi[2] = rg_idx;
    assign oi[3] = ri_idx;
    assign oi[4] = rf_idx;

    always_comb begin
        nxt = bits;
        dbl = 1'b0;
        bad = 1'b0;
        for (int j = 0; j < NOPS; j++) begin
            if (ov[j]) begin
                for (int k = 0; k < TOTAL; k++) begin
                    if (int'(oi[j]) == k) begin
                        if (os[j]) begin
                            if (nxt[k]) dbl = 1'b1;
                            nxt[k] = 1'b1;
                        end else begin
                            if (!nxt[k]) bad = 1'b1;
                            nxt[k] = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits    <= INIT;
            err_dbl <= 1'b0;
            err_bad <= 1'b0;
        end else begin
            bits    <= nxt;
            err_dbl <= dbl;
            err_bad <= bad;
        end
    end

    AST_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_v && !ai_v && !af_v && is_set(bits, ri_idx)) |=> err_dbl); // R7
    AST_BAD_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (ai_v && int'(ai_idx) < TOTAL && !is_set(bits, ai_idx)) |=> err_bad); // R8
    AST_CLEAN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_v && !rg_v && !ri_v && !ai_v && !af_v && int'(rf_idx) < TOTAL && !is_set(bits, rf_idx))
        |=> (!err_dbl && !err_bad)); // R7

endmodule

// File: rtl/phys_reg_freelist.sv
module phys_reg_freelist #(
    parameter int N_LOG_INT  = 4,
    parameter int N_PHYS_INT = 8,
    parameter int N_LOG_FP   = 2,
    parameter int N_PHYS_FP  = 6,
    parameter int IW         = $clog2(N_PHYS_INT + N_PHYS_FP),
    parameter int ICW        = $clog2(N_PHYS_INT + 1),
    parameter int FCW        = $clog2(N_PHYS_FP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           int_alloc_req,
    output logic [IW-1:0]  int_alloc_idx,
    input  logic           fp_alloc_req,
    output logic [IW-1:0]  fp_alloc_idx,
    input  logic           rel_valid,
    input  logic [IW-1:0]  rel_idx,
    input  logic           int_rel_valid,
    input  logic [IW-1:0]  int_rel_idx,
    input  logic           fp_rel_valid,
    input  logic [IW-1:0]  fp_rel_idx,
    output logic           int_nonempty,
    output logic [ICW-1:0] int_free_cnt,
    output logic           fp_nonempty,
    output logic [FCW-1:0] fp_free_cnt,
    output logic           err_empty_alloc,
    output logic           err_double_free,
    output logic           err_bad_alloc,
    output logic           err_overflow
);
    import frl_pkg::*;

    localparam int TOTAL = N_PHYS_INT + N_PHYS_FP;

    rcls_e gen_cls;
    logic  gen_int;
    logic  gen_fp;
    logic  int_pop;
    logic  fp_pop;
    logic  int_err_empty;
    logic  fp_err_empty;
    logic  int_err_ovf;
    logic  fp_err_ovf;

    always_comb begin
        gen_cls = route_idx(int'(rel_idx), N_PHYS_INT, TOTAL);
        gen_int = rel_valid && (gen_cls == RCLS_INT);
        gen_fp  = rel_valid && (gen_cls == RCLS_FP);
        int_pop = int_alloc_req && int_nonempty;
        fp_pop  = fp_alloc_req && fp_nonempty;
    end

    frl_pool #(
        .DEPTH(N_PHYS_INT), .BASE(0), .SKIP(N_LOG_INT), .IW(IW), .CW(ICW)
    ) u_int_pool (
        .clk(clk), .rst_n(rst_n), .pop_req(int_alloc_req),
        .push0_v(gen_int), .push0_idx(rel_idx),
        .push1_v(int_rel_valid), .push1_idx(int_rel_idx),
        .head_idx(int_alloc_idx), .nonempty(int_nonempty), .count(int_free_cnt),
        .err_empty(int_err_empty), .err_ovf(int_err_ovf)
    );

    frl_pool #(
        .DEPTH(N_PHYS_FP), .BASE(N_PHYS_INT), .SKIP(N_LOG_FP), .IW(IW), .CW(FCW)
    ) u_fp_pool (
        .clk(clk), .rst_n(rst_n), .pop_req(fp_alloc_req),
        .push0_v(gen_fp), .push0_idx(rel_idx),
        .push1_v(fp_rel_valid), .push1_idx(fp_rel_idx),
        .head_idx(fp_alloc_idx), .nonempty(fp_nonempty), .count(fp_free_cnt),
        .err_empty(fp_err_empty), .err_ovf(fp_err_ovf)
    );

    frl_shadow #(
        .TOTAL(TOTAL), .IW(IW), .INT_LO(N_LOG_INT), .INT_HI(N_PHYS_INT),
        .FP_LO(N_PHYS_INT + N_LOG_FP)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .ai_v(int_pop), .ai_idx(int_alloc_idx),
        .af_v(fp_pop), .af_idx(fp_alloc_idx),
        .rg_v(gen_int || gen_fp), .rg_idx(rel_idx),
        .ri_v(int_rel_valid), .ri_idx(int_rel_idx),
        .rf_v(fp_rel_valid), .rf_idx(fp_rel_idx),
        .err_dbl(err_double_free), .err_bad(err_bad_alloc)
    );

    assign err_empty_alloc = int_err_empty || fp_err_empty;
    assign err_overflow    = int_err_ovf || fp_err_ovf;

    AST_GEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && int'(rel_idx) >= TOTAL && !int_rel_valid && !fp_rel_valid
         && !int_alloc_req && !fp_alloc_req) |=> ($stable(int_free_cnt) && $stable(fp_free_cnt))); // R3
    AST_GEN_TO_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && int'(rel_idx) < N_PHYS_INT && !int_rel_valid && !int_alloc_req
         && int'(int_free_cnt) < N_PHYS_INT) |=> (int_free_cnt == $past(int_free_cnt) + 1'b1)); // R3
    AST_GEN_TO_FP: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && int'(rel_idx) >= N_PHYS_INT && int'(rel_idx) < TOTAL && !fp_rel_valid
         && !fp_alloc_req && int'(fp_free_cnt) < N_PHYS_FP) |=> (fp_free_cnt == $past(fp_free_cnt) + 1'b1)); // R3
    AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_nonempty && !rel_valid && !int_rel_valid) |=> !int_nonempty); // R5

endmodule

// File: tb/phys_reg_freelist_test.sv
module phys_reg_freelist_test;
    localparam int NLI = 4;
    localparam int NPI = 8;
    localparam int NLF = 2;
    localparam int NPF = 6;
    localparam int TOT = NPI + NPF;
    localparam int IW  = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          int_alloc_req, fp_alloc_req;
    logic [IW-1:0] int_alloc_idx, fp_alloc_idx;
    logic          rel_valid, int_rel_valid, fp_rel_valid;
    logic [IW-1:0] rel_idx, int_rel_idx, fp_rel_idx;
    logic          int_nonempty, fp_nonempty;
    logic [3:0]    int_free_cnt;
    logic [2:0]    fp_free_cnt;
    logic          err_empty_alloc, err_double_free, err_bad_alloc, err_overflow;

    phys_reg_freelist #(
        .N_LOG_INT(NLI), .N_PHYS_INT(NPI), .N_LOG_FP(NLF), .N_PHYS_FP(NPF)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .int_alloc_req(int_alloc_req), .int_alloc_idx(int_alloc_idx),
        .fp_alloc_req(fp_alloc_req), .fp_alloc_idx(fp_alloc_idx),
        .rel_valid(rel_valid), .rel_idx(rel_idx),
        .int_rel_valid(int_rel_valid), .int_rel_idx(int_rel_idx),
        .fp_rel_valid(fp_rel_valid), .fp_rel_idx(fp_rel_idx),
        .int_nonempty(int_nonempty), .int_free_cnt(int_free_cnt),
        .fp_nonempty(fp_nonempty), .fp_free_cnt(fp_free_cnt),
        .err_empty_alloc(err_empty_alloc), .err_double_free(err_double_free),
        .err_bad_alloc(err_bad_alloc), .err_overflow(err_overflow)
    );

    int qi[$];
    int qf[$];
    bit fb[TOT];
    bit e_emp, e_dbl, e_bad, e_ovf;
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_init();
        qi.delete();
        qf.delete();
        for (int i = NLI; i < NPI; i++) qi.push_back(i);
        for (int i = NPI + NLF; i < TOT; i++) qf.push_back(i);
        for (int k = 0; k < TOT; k++) fb[k] = ((k >= NLI) && (k < NPI)) || (k >= NPI + NLF);
        e_emp = 0; e_dbl = 0; e_bad = 0; e_ovf = 0;
    endtask

    task automatic check_state(string tag);
        chk(tag, "int_free_cnt", int'(int_free_cnt), qi.size());
        chk(tag, "fp_free_cnt", int'(fp_free_cnt), qf.size());
        chk(tag, "int_nonempty", int'(int_nonempty), (qi.size() > 0) ? 1 : 0);
        chk(tag, "fp_nonempty", int'(fp_nonempty), (qf.size() > 0) ? 1 : 0);
        if (qi.size() > 0) chk(tag, "int_head", int'(int_alloc_idx), qi[0]);
        if (qf.size() > 0) chk(tag, "fp_head", int'(fp_alloc_idx), qf[0]);
        chk(tag, "err_empty_alloc", int'(err_empty_alloc), int'(e_emp));
        chk(tag, "err_double_free", int'(err_double_free), int'(e_dbl));
        chk(tag, "err_bad_alloc", int'(err_bad_alloc), int'(e_bad));
        chk(tag, "err_overflow", int'(err_overflow), int'(e_ovf));
    endtask

    task automatic rel_int(int idx);
        if (idx < TOT) begin
            if (fb[idx]) e_dbl = 1;
            fb[idx] = 1;
        end
        if (qi.size() < NPI) qi.push_back(idx); else e_ovf = 1;
    endtask

    task automatic rel_fp(int idx);
        if (idx < TOT) begin
            if (fb[idx]) e_dbl = 1;
            fb[idx] = 1;
        end
        if (qf.size() < NPF) qf.push_back(idx); else e_ovf = 1;
    endtask

    task automatic step(string tag, bit ia, bit fa, bit rv, int ri,
                        bit irv, int iri, bit frv, int fri);
        int idx;
        int_alloc_req = ia;  fp_alloc_req = fa;
        rel_valid = rv;      rel_idx = IW'(ri);
        int_rel_valid = irv; int_rel_idx = IW'(iri);
        fp_rel_valid = frv;  fp_rel_idx = IW'(fri);
        #1;
        if (ia && qi.size() > 0) chk(tag, "int_alloc_idx", int'(int_alloc_idx), qi[0]);
        if (fa && qf.size() > 0) chk(tag, "fp_alloc_idx", int'(fp_alloc_idx), qf[0]);
        e_emp = 0; e_dbl = 0; e_bad = 0; e_ovf = 0;
        if (ia) begin
            if (qi.size() == 0) e_emp = 1;
            else begin
                idx = qi.pop_front();
                if (idx < TOT) begin
                    if (!fb[idx]) e_bad = 1;
                    fb[idx] = 0;
                end
            end
        end
        if (fa) begin
            if (qf.size() == 0) e_emp = 1;
            else begin
                idx = qf.pop_front();
                if (idx < TOT) begin
                    if (!fb[idx]) e_bad = 1;
                    fb[idx] = 0;
                end
            end
        end
        if (rv) begin
            if (ri < NPI) rel_int(ri);
            else if (ri < TOT) rel_fp(ri);
        end
        if (irv) rel_int(iri);
        if (frv) rel_fp(fri);
        @(posedge clk);
        @(negedge clk);
        int_alloc_req = 0; fp_alloc_req = 0;
        rel_valid = 0; int_rel_valid = 0; fp_rel_valid = 0;
        check_state(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        rst_n = 0;
        int_alloc_req = 0; fp_alloc_req = 0;
        rel_valid = 0; int_rel_valid = 0; fp_rel_valid = 0;
        rel_idx = '0; int_rel_idx = '0; fp_rel_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_init();
        #1;
        check_state("R1");
        chk("R1", "int reset count", int'(int_free_cnt), NPI - NLI);
        chk("R1", "fp reset head", int'(fp_alloc_idx), NPI + NLF);

        // R2: drain integer pool in ascending order, then R6 empty allocation
        for (int i = 0; i < NPI - NLI; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R6", "err_empty_alloc", int'(err_empty_alloc), 1);
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "int_nonempty", int'(int_nonempty), 0);

        // R3: generic release over the whole index range
        for (int i = 0; i < 16; i++) step("R3", 0, 0, 1, i, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 15, 0, 0, 0, 0);

        // R2: drain both pools in release order, and one empty FP pop (R6)
        for (int i = 0; i < NPF; i++) step("R2", 0, 1, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < NPI; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0);

        // R4: class ports skip the range check; generic goes first
        step("R4", 0, 0, 0, 0, 1, 9, 1, 2);
        step("R4", 0, 0, 1, 5, 1, 6, 0, 0);
        step("R4", 0, 0, 1, 12, 0, 0, 1, 11);
        for (int i = 0; i < 3; i++) step("R4", 1, 1, 0, 0, 0, 0, 0, 0);

        // R9: simultaneous alloc and release in the same pool
        step("R9", 0, 0, 0, 0, 1, 3, 1, 9);
        step("R9", 1, 0, 0, 0, 1, 2, 0, 0);
        step("R9", 0, 1, 0, 0, 0, 0, 1, 8);

        // R7 / R8: double free, then allocation of the duplicate
        step("R7", 0, 0, 0, 0, 1, 1, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 1, 0, 0);
        chk("R7", "err_double_free", int'(err_double_free), 1);
        for (int i = 0; i < 6; i++) step("R8", 1, 0, 0, 0, 0, 0, 0, 0);

        // R10: fill the integer pool past its depth
        for (int i = 0; i < NPI + 2; i++) step("R10", 0, 0, 0, 0, 1, i % NPI, 0, 0);
        chk("R10", "int_free_cnt full", int'(int_free_cnt), NPI);
        step("R10", 0, 0, 1, 0, 1, 1, 0, 0);

        // Near-exhaustive mixed traffic
        for (int c = 0; c < 3000; c++) begin
            step("R2", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), $urandom_range(0, 15),
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 15),
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 15));
        end

        finish_run();
    end

endmodule